// File: doc/BRIEF.md
# Split-Phase SCL Timer

This block produces the SCL timing for an I2C master. It runs from the peripheral clock and is set by a single divider word. The word has two fields. One sets how long SCL stays high. The other sets how long SCL stays low. Each half period lasts eight times (field + 1) peripheral clocks. Because the two fields are independent, the duty cycle can be set freely. For example, a longer low phase gives the data line more settling time.

The bit engine that sits beside this block uses its outputs:
- the intended SCL level;
- a pulse at every SCL transition;
- four quarter pulses inside every half period, with the index of the current quarter, so SDA can be changed during low phases and sampled during high phases;
- a free-running prescaler strobe.

Each half period is counted against a field value that was latched at the SCL edge where that half began. Rewriting the divider word therefore never distorts a half period that is already running. While the block is disabled, SCL rests high. Every enable begins with a full low phase.

Top module: `scl_split_timer`

## Requirements
- R1: While reset is active, or while `enable` is low after reset, `scl_level` is 1, `phase_tick` and `quarter_tick` are 0, `quarter_idx` is 0 and `presc_tick` is 0.
- R2: In the first cycle after the first clock edge that samples `enable` high, `scl_level` is 0 and `phase_tick` is 1. That low phase has full length.
- R3: A low phase lasts exactly 8 × (L + 1) clock cycles. L is the unsigned value of `div_word[FIELD_W-1:0]` (bits 15:0 by default).
- R4: A high phase lasts exactly 8 × (H + 1) clock cycles. H is the unsigned value of `div_word[2*FIELD_W-1:FIELD_W]` (bits 31:16 by default). One SCL period therefore lasts 8 × ((L + 1) + (H + 1)) cycles.
- R5: L and H act independently, so the low and high phases can have different lengths. For example, L = 7 and H = 5 give a 64:48 split.
- R6: `phase_tick` is a one-cycle pulse in the first cycle of each new SCL level, and it pulses at no other time.
- R7: Within a half period based on field value F, `quarter_tick` pulses at cycle offsets 0, 2(F+1), 4(F+1) and 6(F+1) from the phase start. While `quarter_tick` is high, `quarter_idx` gives that quarter's number: 0, 1, 2 or 3.
- R8: While running, `presc_tick` pulses once every 2 cycles, on the second cycle after the start and on every other cycle after that. It never stays high for two cycles in a row.
- R9: A change to `div_word` has no effect on the half period in progress. The new value is picked up only at the next SCL edge.
- R10: When `enable` is sampled low, the next cycle shows `scl_level` = 1 and all counters cleared. A later enable begins with a full low phase.
- R11: An all-ones field gives the longest half period, 8 × 2^FIELD_W cycles, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator when high; holds SCL high when low |
| div_word | input | 2*FIELD_W | High-duration field in the upper half, low-duration field in the lower half |
| scl_level | output | 1 | Intended SCL level |
| phase_tick | output | 1 | One-cycle pulse at every SCL transition |
| quarter_tick | output | 1 | One-cycle pulse at the start of each quarter of a half period |
| quarter_idx | output | 2 | Number of the current quarter |
| presc_tick | output | 1 | Free-running prescaler strobe while the generator runs |

## Verification
The bench builds two copies of the block. The first uses the default widths (FIELD_W = 16, PRESC = 8) and covers start-up, asymmetric and minimum-length phases, quarter placement, reprogramming in mid-phase, and stopping and restarting. The second uses FIELD_W = 4. With that width an all-ones field is only 128 cycles per half, so the longest-count and no-wrap case can be checked quickly, along with the way the field boundary moves as the word width changes.

// File: rtl/scl_timer_pkg.sv
`timescale 1ns/1ps
package scl_timer_pkg;

  // Length of one half period in peripheral clocks for a given field value.
  function automatic logic [31:0] half_cycles(input logic [31:0] field,
                                              input int unsigned presc);
    return 32'(presc) * (field + 32'd1);
  endfunction

  // Length of one quarter of a half period.
  function automatic logic [31:0] quarter_cycles(input logic [31:0] field,
                                                 input int unsigned presc);
    return half_cycles(field, presc) >> 2;
  endfunction

endpackage

// File: rtl/scl_presc.sv
`timescale 1ns/1ps
// Divides the clock into base steps; four steps per field count give the
// overall divide-by-PRESC.
module scl_presc #(
  parameter int unsigned SUB = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (SUB > 1) begin : g_cnt
      localparam int unsigned SW = $clog2(SUB);
      logic [SW-1:0] sub_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       sub_q <= '0;
        else if (!run)                    sub_q <= '0;
        else if (sub_q == SW'(SUB - 1))   sub_q <= '0;
        else                              sub_q <= sub_q + 1'b1;
      end

      assign tick = run && (sub_q == SW'(SUB - 1));

      AST_PRESC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R8
    end else begin : g_pass
      assign tick = run;
    end
  endgenerate
endmodule

// File: rtl/scl_half_cnt.sv
`timescale 1ns/1ps
// Counts field+1 steps per quarter and four quarters per half period.
module scl_half_cnt #(
  parameter int unsigned FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               step,
  input  logic [FIELD_W-1:0] field,
  output logic               quarter_done,
  output logic               half_done,
  output logic [1:0]         qidx
);
  logic [FIELD_W-1:0] fcnt_q;
  logic               fcnt_wrap;

  assign fcnt_wrap    = (fcnt_q == field);
  assign quarter_done = step && fcnt_wrap;
  assign half_done    = quarter_done && (qidx == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      qidx   <= '0;
    end else if (!run) begin
      fcnt_q <= '0;
      qidx   <= '0;
    end else if (step) begin
      if (fcnt_wrap) begin
        fcnt_q <= '0;
        qidx   <= qidx + 2'd1;
      end else begin
        fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

  AST_FCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (fcnt_q <= field)); // R11
  AST_QIDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    quarter_done |=> (qidx == $past(qidx) + 2'd1)); // R7
endmodule

// File: rtl/scl_phase_ctrl.sv
`timescale 1ns/1ps
// Holds the SCL level, latches the active field at each edge and registers
// the phase and quarter pulses.
module scl_phase_ctrl
  import scl_timer_pkg::*;
#(
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned PRESC   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [2*FIELD_W-1:0] div_word,
  input  logic                 quarter_done,
  input  logic                 half_done,
  output logic                 run,
  output logic [FIELD_W-1:0]   field,
  output logic                 scl_level,
  output logic                 phase_tick,
  output logic                 quarter_tick
);
  logic               active_q;
  logic               start;
  logic [FIELD_W-1:0] lo_field;
  logic [FIELD_W-1:0] hi_field;

  assign lo_field = div_word[FIELD_W-1:0];
  assign hi_field = div_word[2*FIELD_W-1:FIELD_W];
  assign start    = enable && !active_q;
  assign run      = enable && active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q     <= 1'b0;
      scl_level    <= 1'b1;
      field        <= '0;
      phase_tick   <= 1'b0;
      quarter_tick <= 1'b0;
    end else if (!enable) begin
      active_q     <= 1'b0;
      scl_level    <= 1'b1;
      phase_tick   <= 1'b0;
      quarter_tick <= 1'b0;
    end else if (start) begin
      active_q     <= 1'b1;
      scl_level    <= 1'b0;
      field        <= lo_field;
      phase_tick   <= 1'b1;
      quarter_tick <= 1'b1;
    end else begin
      phase_tick   <= half_done;
      quarter_tick <= quarter_done;
      if (half_done) begin
        scl_level <= ~scl_level;
        field     <= scl_level ? lo_field : hi_field;
      end
    end
  end

  // Cycle count since the current phase began, kept for the checks below.
  logic [31:0] len_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       len_cnt <= '0;
    else if (start || half_done)      len_cnt <= '0;
    else if (run)                     len_cnt <= len_cnt + 32'd1;
    else                              len_cnt <= '0;
  end

  AST_HALF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && half_done) |-> (len_cnt == half_cycles(32'(field), PRESC) - 32'd1)); // R3
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !half_done) |=> $stable(field)); // R9
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_level && !phase_tick && !quarter_tick)); // R10
  AST_FALL_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_level) |-> phase_tick); // R6
endmodule

// File: rtl/scl_split_timer.sv
`timescale 1ns/1ps
module scl_split_timer #(
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned PRESC   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [2*FIELD_W-1:0] div_word,
  output logic                 scl_level,
  output logic                 phase_tick,
  output logic                 quarter_tick,
  output logic [1:0]           quarter_idx,
  output logic                 presc_tick
);
  localparam int unsigned SUB = PRESC / 4;

  initial begin
    AST_PRESC_SHAPE: assert (PRESC >= 4 && PRESC % 4 == 0); // R8
  end

  logic               run;
  logic               step;
  logic               quarter_done;
  logic               half_done;
  logic [FIELD_W-1:0] field;

  scl_phase_ctrl #(.FIELD_W(FIELD_W), .PRESC(PRESC)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .div_word     (div_word),
    .quarter_done (quarter_done),
    .half_done    (half_done),
    .run          (run),
    .field        (field),
    .scl_level    (scl_level),
    .phase_tick   (phase_tick),
    .quarter_tick (quarter_tick)
  );

  scl_presc #(.SUB(SUB)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (step)
  );

  scl_half_cnt #(.FIELD_W(FIELD_W)) u_half (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .step         (step),
    .field        (field),
    .quarter_done (quarter_done),
    .half_done    (half_done),
    .qidx         (quarter_idx)
  );

  assign presc_tick = step;

  AST_PHASE_QUARTER0: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |-> (quarter_tick && quarter_idx == 2'd0)); // R7
  AST_PHASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |=> !phase_tick); // R6
endmodule

// File: tb/tb_scl_split_timer.sv
`timescale 1ns/1ps
module tb_scl_split_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] div = '0;
  logic        scl, ph, qt, pt;
  logic [1:0]  qi;

  logic        en_n = 1'b0;
  logic [7:0]  div_n = '0;
  logic        scl_n, ph_n, qt_n, pt_n;
  logic [1:0]  qi_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  scl_split_timer dut (
    .clk(clk), .rst_n(rst_n), .enable(en), .div_word(div),
    .scl_level(scl), .phase_tick(ph), .quarter_tick(qt),
    .quarter_idx(qi), .presc_tick(pt)
  );

  scl_split_timer #(.FIELD_W(4), .PRESC(8)) dut_narrow (
    .clk(clk), .rst_n(rst_n), .enable(en_n), .div_word(div_n),
    .scl_level(scl_n), .phase_tick(ph_n), .quarter_tick(qt_n),
    .quarter_idx(qi_n), .presc_tick(pt_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts cycles while scl stays at lvl; ends on the first cycle of the next level.
  task automatic count_level(input logic lvl, output int n, output int ticks);
    n = 0; ticks = 0;
    while (scl == lvl && en && n < 100000) begin
      if (ph) ticks++;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic go_idle();
    en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(scl == 1'b1, "R1 scl in reset", int'(scl), 1);
    check(!ph && !qt && !pt, "R1 ticks in reset", int'({ph, qt, pt}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(scl == 1'b1 && qi == 2'd0, "R1 idle after reset", int'({scl, qi}), 4);
    check(!ph && !qt && !pt, "R1 idle ticks", int'({ph, qt, pt}), 0);
  endtask

  task automatic t_asym();
    int nl, nh, tk;
    go_idle();
    div = {16'd5, 16'd7};
    en = 1'b1;
    @(negedge clk);
    check(scl == 1'b0 && ph == 1'b1, "R2 start low with tick", int'({scl, ph}), 1);
    count_level(1'b0, nl, tk);
    check(nl == 64, "R3 low length", nl, 64);
    check(tk == 1, "R6 one tick in low", tk, 1);
    check(scl == 1'b1 && ph == 1'b1, "R6 tick at rise", int'({scl, ph}), 3);
    count_level(1'b1, nh, tk);
    check(nh == 48, "R4 high length", nh, 48);
    check(nl + nh == 112 && nl > nh, "R5 asymmetric period", nl + nh, 112);
    check(ph == 1'b1 && scl == 1'b0, "R6 tick at fall", int'({scl, ph}), 1);
    @(negedge clk);
    check(ph == 1'b0, "R6 single cycle", int'(ph), 0);
  endtask

  task automatic t_min();
    int nl, nh, tk;
    go_idle();
    div = 32'd0;
    en = 1'b1;
    @(negedge clk);
    count_level(1'b0, nl, tk);
    check(nl == 8, "R3 minimum low", nl, 8);
    count_level(1'b1, nh, tk);
    check(nh == 8, "R4 minimum high", nh, 8);
  endtask

  task automatic t_quarters();
    int q, npt, dbl;
    logic prev;
    go_idle();
    div = {16'd2, 16'd3};
    en = 1'b1;
    @(negedge clk);
    q = 0; npt = 0; dbl = 0; prev = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (qt) begin
        check(i == q * 8 && qi == 2'(q), "R7 low quarter position", i, q * 8);
        q++;
      end
      if (pt) npt++;
      if (pt && prev) dbl++;
      prev = pt;
      @(negedge clk);
    end
    check(q == 4, "R7 four low quarters", q, 4);
    check(npt == 16, "R8 presc count", npt, 16);
    check(dbl == 0, "R8 no back-to-back presc", dbl, 0);
    q = 0;
    for (int i = 0; i < 24; i++) begin
      if (qt) begin
        check(i == q * 6 && qi == 2'(q), "R7 high quarter position", i, q * 6);
        q++;
      end
      @(negedge clk);
    end
    check(q == 4, "R7 four high quarters", q, 4);
    en = 1'b0;
    @(negedge clk);
    check(pt == 1'b0 && qi == 2'd0, "R8 presc stops", int'({pt, qi}), 0);
  endtask

  task automatic t_reprogram();
    int n, tk;
    go_idle();
    div = {16'd2, 16'd3};
    en = 1'b1;
    @(negedge clk);
    repeat (5) @(negedge clk);
    div = {16'd5, 16'd1};
    count_level(1'b0, n, tk);
    check(n + 5 == 32, "R9 running low unchanged", n + 5, 32);
    count_level(1'b1, n, tk);
    check(n == 48, "R9 new high taken at edge", n, 48);
    count_level(1'b0, n, tk);
    check(n == 16, "R9 new low taken at edge", n, 16);
  endtask

  task automatic t_disable();
    int n, tk, bad;
    repeat (7) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(scl == 1'b1 && ph == 1'b0, "R10 scl high after disable", int'({scl, ph}), 2);
    check(qi == 2'd0 && pt == 1'b0, "R10 counters cleared", int'({qi, pt}), 0);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      if (!scl || qt) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R10 stays idle", bad, 0);
    div = {16'd2, 16'd3};
    en = 1'b1;
    @(negedge clk);
    check(scl == 1'b0 && ph == 1'b1, "R10 restart low", int'({scl, ph}), 1);
    count_level(1'b0, n, tk);
    check(n == 32, "R10 full low after restart", n, 32);
    go_idle();
  endtask

  task automatic t_narrow_max();
    int nl, nh;
    div_n = 8'hFF;
    en_n = 1'b1;
    @(negedge clk);
    check(scl_n == 1'b0, "R11 narrow start low", int'(scl_n), 0);
    nl = 0;
    while (scl_n == 1'b0 && nl < 10000) begin nl++; @(negedge clk); end
    check(nl == 128, "R11 max low", nl, 128);
    nh = 0;
    while (scl_n == 1'b1 && nh < 10000) begin nh++; @(negedge clk); end
    check(nh == 128, "R11 max high", nh, 128);
    en_n = 1'b0;
    div_n = 8'h31;
    @(negedge clk);
    en_n = 1'b1;
    @(negedge clk);
    nl = 0;
    while (scl_n == 1'b0 && nl < 10000) begin nl++; @(negedge clk); end
    check(nl == 16, "R3 narrow low field", nl, 16);
    nh = 0;
    while (scl_n == 1'b1 && nh < 10000) begin nh++; @(negedge clk); end
    check(nh == 32, "R4 narrow high field", nh, 32);
    en_n = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_asym();
    t_min();
    t_quarters();
    t_reprogram();
    t_disable();
    t_narrow_max();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule